// File: doc/BRIEF.md
# RAM-Backed Sweeping Shift Line

This block keeps a long, word-wide delay line in a simple dual-port synchronous RAM rather than in flip-flops. A long filter delay line can then live in memory and leave the logic fabric free. The line advances by one whole sample per sweep. A sequencer visits every address in increasing order, one address per clock. Address zero takes a freshly captured input sample. Every other address takes the word that the previous address held before the sweep began, read back from the RAM one cycle earlier.

While a sweep runs, the word written at each address is also presented on a serial tap stream, one word per clock, so that a downstream multiply-accumulate can consume the whole line in address order. A one-clock completion pulse marks the final entry. Holding the enable high across the end of a sweep chains the next sweep directly behind it, with no idle clock between them.

Top module: `rsl_shift_line`

## Requirements
- R1: The line length `DEPTH` (default 444) and word width `WIDTH` (default 16) are parameters, and the address width is derived from `DEPTH` (9 bits at the default). Every sweep emits exactly `DEPTH` tap words.
- R2: When `en` is high at a rising edge while the block is idle, `sample_in` is captured at that edge and a sweep starts at address 0. `tap_valid` stays low on the first clock after that start edge.
- R3: After a sweep, entry 0 holds the captured sample and entry k (for k ≥ 1) holds the value entry k-1 held before the sweep. Memory contents carry over from sweep to sweep.
- R4: Tap word k (address k, counting from 0) is valid on the (k+1)-th clock after the start edge. `tap_valid` is high for `DEPTH` consecutive clocks, and `tap_data` equals the post-sweep content of entry k.
- R5: `sweep_done` is high for exactly one clock, together with the tap word of address `DEPTH-1`.
- R6: While a sweep runs, `en` and `sample_in` are ignored, except at the edge that ends the clock holding the last address.
- R7: If `en` is high at the edge that ends the last-address clock, the next sweep starts at once, capturing `sample_in` at that edge. Its tap 0 follows on the clock after `sweep_done`.
- R8: With `en` low, an idle block stays idle, with `tap_valid` and `sweep_done` low. A sweep that ends with `en` low returns to idle, and both outputs are low on the next clock.
- R9: Synchronous active-high `rst` drives `tap_valid` and `sweep_done` low and returns the sequencer to idle at address 0, abandoning any sweep in progress. No new sweep starts without `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Start or chain a sweep |
| sample_in | input | WIDTH | New sample, captured at the start edge |
| tap_data | output | WIDTH | Serial line content in address order |
| tap_valid | output | 1 | Tap word valid strobe |
| sweep_done | output | 1 | One-clock pulse with the last tap |

## Verification
Counting from the edge that samples `en` high, tap k is due k+1 clocks later and `sweep_done` is due `DEPTH` clocks later. Both outputs are due low one clock after the final tap, unless a chained start has occurred. The bench drives inputs on falling edges and samples outputs one falling edge after each rising edge. It walks exactly these counts, so each expected word is compared in the cycle it is due against a flip-flop model shifted once per sweep. Entries whose content is still unknown after power-up or after an abandoned sweep are skipped, because the model has no value for them.

// File: rtl/rsl_pkg.sv
package rsl_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Address width for a line of n entries (at least one bit).
  function automatic int unsigned line_addr_bits(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rsl_sdp_ram.sv
module rsl_sdp_ram #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 444,
  parameter int unsigned AW    = 9
) (
  input  logic             clk,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_q,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data
);

  logic [WIDTH-1:0] mem [0:DEPTH-1];

  // Registered read: when the read and write addresses collide, the read returns the old word.
  always_ff @(posedge clk) begin
    rd_q <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

endmodule

// File: rtl/rsl_sweep_seq.sv
module rsl_sweep_seq
  import rsl_pkg::*;
#(
  parameter int unsigned DEPTH = 444,
  parameter int unsigned AW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          start_evt,
  output logic          active,
  output logic          last_evt,
  output logic [AW-1:0] adr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  seq_state_e state;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + 1'b1;
  endfunction

  assign active    = (state == SEQ_RUN);
  assign last_evt  = active && (adr == LAST);
  assign start_evt = en && (!active || last_evt);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      adr   <= '0;
    end else if (start_evt) begin
      state <= SEQ_RUN;
      adr   <= '0;
    end else if (last_evt) begin
      state <= SEQ_IDLE;
      adr   <= '0;
    end else if (active) begin
      adr   <= step_addr(adr);
    end
  end

  // R4
  adr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !last_evt) |=> (active && adr == AW'($past(adr) + 1'b1)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!active && !en) |=> !active);

  // R1
  adr_range_chk: assert property (@(posedge clk) disable iff (rst)
    adr <= LAST);

endmodule

// File: rtl/rsl_tap_stage.sv
module rsl_tap_stage #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             last_evt,
  output logic [WIDTH-1:0] tap_data,
  output logic             tap_valid,
  output logic             sweep_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_valid  <= 1'b0;
      sweep_done <= 1'b0;
    end else begin
      tap_valid  <= wr_en;
      sweep_done <= last_evt;
    end
    tap_data <= wr_data;
  end

  // R5
  done_with_tap_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_done |-> tap_valid);

endmodule

// File: rtl/rsl_shift_line.sv
module rsl_shift_line
  import rsl_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 444
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] sample_in,
  output logic [WIDTH-1:0] tap_data,
  output logic             tap_valid,
  output logic             sweep_done
);

  localparam int unsigned AW = line_addr_bits(DEPTH);

  logic             start_evt;
  logic             active;
  logic             last_evt;
  logic [AW-1:0]    adr;
  logic [WIDTH-1:0] hold_q;
  logic [WIDTH-1:0] rd_q;
  logic [WIDTH-1:0] wr_data;
  logic             wr_en;

  // Entry 0 takes the captured sample; any other entry takes its predecessor's read-back.
  function automatic logic [WIDTH-1:0] pick_word(input logic [AW-1:0] a,
                                                 input logic [WIDTH-1:0] fresh,
                                                 input logic [WIDTH-1:0] fed_back);
    return (a == '0) ? fresh : fed_back;
  endfunction

  rsl_sweep_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .start_evt (start_evt),
    .active    (active),
    .last_evt  (last_evt),
    .adr       (adr)
  );

  always_ff @(posedge clk) begin
    if (start_evt) hold_q <= sample_in;
  end

  assign wr_en   = active;
  assign wr_data = pick_word(adr, hold_q, rd_q);

  rsl_sdp_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk     (clk),
    .rd_addr (adr),
    .rd_q    (rd_q),
    .wr_en   (wr_en),
    .wr_addr (adr),
    .wr_data (wr_data)
  );

  rsl_tap_stage #(.WIDTH(WIDTH)) u_tap (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .last_evt   (last_evt),
    .tap_data   (tap_data),
    .tap_valid  (tap_valid),
    .sweep_done (sweep_done)
  );

  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> (wr_en && adr == '0 && wr_data == $past(sample_in)));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sweep_done |=> !sweep_done);

  // R7
  chain_start_chk: assert property (@(posedge clk) disable iff (rst)
    (last_evt && en) |=> (active && adr == '0));

endmodule

// File: tb/rsl_shift_line_tb.sv
module rsl_shift_line_tb;

  localparam int unsigned W  = 16;
  localparam int unsigned D  = 12;
  localparam int unsigned NV = 16;

  // Vector: {idle gap [20:17], chain into next [16], sample [15:0]}
  localparam logic [20:0] VEC [0:NV-1] = '{
    {4'd2, 1'b0, 16'hA5C3}, {4'd0, 1'b1, 16'h1234}, {4'd0, 1'b1, 16'hFFFF},
    {4'd0, 1'b0, 16'h0000}, {4'd3, 1'b0, 16'h7E01}, {4'd1, 1'b1, 16'h8001},
    {4'd0, 1'b0, 16'h5A5A}, {4'd0, 1'b0, 16'hC0DE}, {4'd5, 1'b1, 16'h0F0F},
    {4'd0, 1'b1, 16'hBEEF}, {4'd0, 1'b0, 16'h3141}, {4'd2, 1'b0, 16'h2718},
    {4'd1, 1'b1, 16'hDEAD}, {4'd0, 1'b0, 16'h4242}, {4'd4, 1'b0, 16'h9999},
    {4'd0, 1'b0, 16'h0101}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en  = 1'b0;
  logic [W-1:0] sample_in = '0;
  logic [W-1:0] tap_data;
  logic         tap_valid;
  logic         sweep_done;

  int           n_checks = 0;
  int           n_errors = 0;
  bit           finished = 1'b0;
  logic [15:0]  lfsr = 16'hACE1;
  logic [W-1:0] model [0:D-1];
  bit           known [0:D-1];

  always #2.5 clk = ~clk;

  rsl_shift_line #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .sample_in  (sample_in),
    .tap_data   (tap_data),
    .tap_valid  (tap_valid),
    .sweep_done (sweep_done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic junk_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic model_shift(input logic [W-1:0] s);
    for (int i = D - 1; i > 0; i--) begin
      model[i] = model[i-1];
      known[i] = known[i-1];
    end
    model[0] = s;
    known[0] = 1'b1;
  endtask

  task automatic do_sweep(input logic [W-1:0] s, input bit chain_in,
                          input bit chain_out, input logic [W-1:0] s_next);
    int taps = 0;
    if (!chain_in) begin
      en = 1'b1;
      sample_in = s;
      @(posedge clk); @(negedge clk);
      check(tap_valid == 1'b0, "R2 no tap in first clock", 32'(tap_valid), 0);
    end
    model_shift(s);
    for (int k = 0; k < int'(D); k++) begin
      if (k <= int'(D) - 3) begin
        junk_step();
        en = lfsr[0];        // R6 ignored mid-sweep
        sample_in = lfsr;
      end else if (k == int'(D) - 2) begin
        en = chain_out;
        sample_in = s_next;
      end
      @(posedge clk); @(negedge clk);
      taps += tap_valid ? 1 : 0;
      check(tap_valid == 1'b1, "R4 tap_valid", 32'(tap_valid), 1);
      if (known[k])
        check(tap_data == model[k], "R3 tap word", 32'(tap_data), 32'(model[k]));
      check(sweep_done == (k == int'(D) - 1), "R5 sweep_done", 32'(sweep_done),
            32'(k == int'(D) - 1));
      if (k == int'(D) - 1 && chain_out)
        check(tap_valid && sweep_done, "R7 chained end", 32'(sweep_done), 1);
    end
    check(taps == int'(D), "R1 taps per sweep", 32'(taps), 32'(D));
    if (!chain_out) begin
      en = 1'b0;
      @(posedge clk); @(negedge clk);
      check(!tap_valid && !sweep_done, "R8 idle after sweep",
            {tap_valid, sweep_done}, 0);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < int'(D); i++) begin
      model[i] = '0;
      known[i] = 1'b0;
    end
    // R9 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!tap_valid && !sweep_done, "R9 outputs in reset", {tap_valid, sweep_done}, 0);
    rst = 1'b0;
    // R8 idle without enable
    for (int i = 0; i < 6; i++) begin
      junk_step();
      sample_in = lfsr;
      @(posedge clk); @(negedge clk);
      check(!tap_valid && !sweep_done, "R8 idle stays idle", {tap_valid, sweep_done}, 0);
    end

    // Table walk
    for (int v = 0; v < int'(NV); v++) begin
      bit cin;
      bit cout;
      logic [W-1:0] nxt;
      cin  = (v > 0) ? VEC[v-1][16] : 1'b0;
      cout = VEC[v][16];
      nxt  = (v + 1 < int'(NV)) ? VEC[v+1][15:0] : '0;
      if (!cin) begin
        for (int g = 0; g < int'(VEC[v][20:17]); g++) begin
          en = 1'b0;
          @(posedge clk); @(negedge clk);
          check(!tap_valid, "R8 idle gap", 32'(tap_valid), 0);
        end
      end
      do_sweep(VEC[v][15:0], cin, cout, nxt);
    end

    // R9 reset in the middle of a sweep
    en = 1'b1;
    sample_in = 16'h6666;
    @(posedge clk); @(negedge clk);
    en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tap_valid, "R9 sweep running before reset", 32'(tap_valid), 1);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(!tap_valid && !sweep_done, "R9 reset abandons sweep", {tap_valid, sweep_done}, 0);
    rst = 1'b0;
    for (int i = 0; i < int'(D) + 2; i++) begin
      @(posedge clk); @(negedge clk);
      check(!tap_valid && !sweep_done, "R9 no restart after reset",
            {tap_valid, sweep_done}, 0);
    end
    for (int i = 0; i < int'(D); i++) known[i] = 1'b0;
    do_sweep(16'h1357, 1'b0, 1'b1, 16'h2468);
    do_sweep(16'h2468, 1'b1, 1'b0, 16'h0000);
    do_sweep(16'hFACE, 1'b0, 1'b0, 16'h0000);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule